// File: doc/BRIEF.md
# Striped Spare-Bit Byte Memory

This block is an 8192-byte random-access memory with byte-wide reads and writes. It takes a 13-bit byte address, a write strobe and 8-bit write data. It returns 8-bit read data from a register one clock after the address is presented. Storage is seven banks of 1024 nine-bit words plus a side column of 1024 single bits. Each of the seven lower kilobytes uses the low eight bits of one bank. The top kilobyte is built from the ninth bit of every bank, all read at the same word index, together with the side-column bit at that index.

Each access maps to a word index and a bank field with no arithmetic, so every read and every write finishes in one clock cycle. The block needs no sequencer. It suits program or data storage where the full power-of-two capacity must fit in storage whose natural word width is nine bits.

Top module: `stripe_byte_ram`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, `rdata` reads 0x00 after that edge.
- R2: For an address in 0x0000–0x1BFF, bits 12..10 select bank 0 to 6 and bits 9..0 select the word. A byte written there reads back unchanged.
- R3: For an address in 0x1C00–0x1FFF, data bit i (i = 0..6) is stored in bit 8 of bank i, and data bit 7 is stored in the side column, all at word bits 9..0. A byte written there reads back unchanged, including at 0x1C00 and 0x1FFF.
- R4: A write to the lower region changes only bits 7..0 of the selected bank word. The top-region byte and the other banks' bytes at the same word index keep their values.
- R5: A write to the top region changes only the ninth bits and the side-column bit at that index. None of the seven lower-region bytes at that index change.
- R6: `rdata` after a rising edge holds the content of the address sampled at that edge. This applies on every cycle, whether `wr_en` is high or low.
- R7: When a read and a write hit the same address at the same edge, `rdata` returns the content from before the write.
- R8: With `wr_en` low, no stored byte changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the read register and the region select |
| addr | input | 13 | Byte address for the read and the write |
| wr_en | input | 1 | Writes `wdata` to `addr` at the rising edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for the previous cycle's address |

## Verification
The bench focuses on aliasing between the two regions that share a word index. It writes a lower-region byte and a top-region byte at the same index and reads both back. A design that masked the wrong bits would corrupt the neighbour byte, and a design that routed a bit to the wrong bank would scramble the top byte. It also covers the boundary addresses 0x1BFF and 0x1C00, where a wrong region decode would alias bank 6 with the striped region. Reads that coincide with writes are checked so that a write-through design is caught. Random traffic uses addresses clustered on a few word indices so that cross-region overwrites happen often, and every result is compared with a flat byte model.

// File: rtl/stripe_ram_pkg.sv
// Package: shared region type for the striped byte memory.
// Assumes the region decision is a single bit (lower banks vs striped top).
package stripe_ram_pkg;
    typedef enum logic {
        REGION_BANK   = 1'b0,
        REGION_STRIPE = 1'b1
    } region_e;
endpackage

// File: rtl/stripe_ram_decode.sv
// Module: address decode for the striped byte memory.
// Splits the byte address into a bank field and a word index, and produces
// per-bank low-byte write enables plus one striped write enable.
// Assumes bank field values at or above BANKS select the striped region.
module stripe_ram_decode
    import stripe_ram_pkg::*;
#(
    parameter int BANKS  = 7,
    parameter int SEL_W  = 3,
    parameter int IDX_W  = 10,
    localparam int ADDR_W = SEL_W + IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output region_e           region,
    output logic [SEL_W-1:0]  bank_sel,
    output logic [IDX_W-1:0]  word_idx,
    output logic [BANKS-1:0]  low_we,
    output logic              stripe_we
);
    // Field split and region choice.
    always_comb begin
        bank_sel = addr[ADDR_W-1 -: SEL_W];
        word_idx = addr[IDX_W-1:0];
        region   = (int'(bank_sel) >= BANKS) ? REGION_STRIPE : REGION_BANK;
    end

    // Write enables: one bank's low byte, or every spare bit at once.
    always_comb begin
        low_we    = '0;
        stripe_we = wr_en && (region == REGION_STRIPE);
        for (int b = 0; b < BANKS; b++) begin
            low_we[b] = wr_en && (region == REGION_BANK) && (int'(bank_sel) == b);
        end
    end
endmodule

// File: rtl/stripe_ram_bank.sv
// Module: one nine-bit-wide storage bank, behavioural.
// The low byte and the ninth bit take independent write strobes. Reads come
// out of a register that returns the old word on a same-address write.
// Assumes the array is not reset; only the read register is.
module stripe_ram_bank #(
    parameter int IDX_W  = 10,
    parameter int BYTE_W = 8,
    localparam int DEPTH  = 1 << IDX_W,
    localparam int WORD_W = BYTE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              low_we,
    input  logic [BYTE_W-1:0] low_d,
    input  logic              spare_we,
    input  logic              spare_d,
    output logic [WORD_W-1:0] rd_q
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Array update: each field is written only under its own strobe.
    always_ff @(posedge clk) begin
        if (low_we)   mem[idx][BYTE_W-1:0] <= low_d;
        if (spare_we) mem[idx][BYTE_W]     <= spare_d;
    end

    // Registered read of the addressed word (old value on collision).
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= mem[idx];
    end

    // Low-byte write lands in the word it addressed.
    assert_bank_low_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        low_we |=> mem[$past(idx)][BYTE_W-1:0] == $past(low_d));

    // Spare-bit write lands in bit 8 of the word it addressed.
    assert_bank_spare_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        spare_we |=> mem[$past(idx)][BYTE_W] == $past(spare_d));
endmodule

// File: rtl/stripe_ram_bitcol.sv
// Module: single-bit side column, behavioural, with a registered read.
// Supplies the eighth data bit of every striped-region byte.
// Assumes the array is not reset; only the read register is.
module stripe_ram_bitcol #(
    parameter int IDX_W = 10,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             we,
    input  logic             d,
    output logic             rd_q
);
    logic col [DEPTH];

    // Bit update under the striped write strobe.
    always_ff @(posedge clk) begin
        if (we) col[idx] <= d;
    end

    // Registered read of the addressed bit.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= col[idx];
    end

    // Side-column write lands at its index.
    assert_col_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> col[$past(idx)] == $past(d));
endmodule

// File: rtl/stripe_byte_ram.sv
// Module: 8 KB byte memory from seven nine-bit banks plus a bit column.
// Lower seven kilobytes use each bank's low byte. The top kilobyte takes
// data bit i from bank i's ninth bit and its top bit from the side column.
// Assumes BANKS == BYTE_W - 1 and a bank field wide enough to hold BANKS.
module stripe_byte_ram
    import stripe_ram_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 10,
    localparam int BANKS  = BYTE_W - 1,
    localparam int SEL_W  = $clog2(BANKS + 1),
    localparam int ADDR_W = SEL_W + IDX_W,
    localparam int WORD_W = BYTE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    region_e           region;
    logic [SEL_W-1:0]  bank_sel;
    logic [IDX_W-1:0]  word_idx;
    logic [BANKS-1:0]  low_we;
    logic              stripe_we;
    logic [WORD_W-1:0] bank_q [BANKS];
    logic              col_q;
    region_e           region_q;
    logic [SEL_W-1:0]  sel_q;
    logic [BYTE_W-1:0] stripe_byte;
    logic [BYTE_W-1:0] bank_byte;

    stripe_ram_decode #(
        .BANKS (BANKS),
        .SEL_W (SEL_W),
        .IDX_W (IDX_W)
    ) u_decode (
        .addr      (addr),
        .wr_en     (wr_en),
        .region    (region),
        .bank_sel  (bank_sel),
        .word_idx  (word_idx),
        .low_we    (low_we),
        .stripe_we (stripe_we)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        stripe_ram_bank #(
            .IDX_W  (IDX_W),
            .BYTE_W (BYTE_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .idx      (word_idx),
            .low_we   (low_we[b]),
            .low_d    (wdata),
            .spare_we (stripe_we),
            .spare_d  (wdata[b]),
            .rd_q     (bank_q[b])
        );
        // Gather ninth bit of bank b into striped data bit b.
        assign stripe_byte[b] = bank_q[b][BYTE_W];
    end

    stripe_ram_bitcol #(
        .IDX_W (IDX_W)
    ) u_col (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (word_idx),
        .we    (stripe_we),
        .d     (wdata[BYTE_W-1]),
        .rd_q  (col_q)
    );
    assign stripe_byte[BYTE_W-1] = col_q;

    // Hold the region and bank choice alongside the registered bank reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            region_q <= REGION_BANK;
            sel_q    <= '0;
        end else begin
            region_q <= region;
            sel_q    <= bank_sel;
        end
    end

    // Pick the low byte of the bank chosen last cycle.
    always_comb begin
        bank_byte = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (int'(sel_q) == b) bank_byte = bank_q[b][BYTE_W-1:0];
        end
    end

    // Output select between lower-bank byte and striped byte.
    assign rdata = (region_q == REGION_STRIPE) ? stripe_byte : bank_byte;

    // Reset clears the read data seen after the edge.
    assert_reset_rdata_R1: assert property (@(posedge clk)
        !rst_n |=> rdata == '0);

    // A write to the top kilobyte strobes no low byte.
    assert_stripe_no_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[ADDR_W-1 -: SEL_W] == SEL_W'(BANKS)) |-> (low_we == '0 && stripe_we));

    // A lower write strobes exactly one bank and no spare bit.
    assert_low_single_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr[ADDR_W-1 -: SEL_W]) < BANKS) |-> ($countones(low_we) == 1 && !stripe_we));

    // No strobe of any kind without a write request.
    assert_idle_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (low_we == '0 && !stripe_we));
endmodule

// File: tb/tb_stripe_byte_ram.sv
// Bench: flat byte model, directed region corners plus seeded random traffic.
module tb_stripe_byte_ram;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [12:0] addr;
    logic        wr_en;
    logic [7:0]  wdata;
    logic [7:0]  rdata;

    logic [7:0]  model [8192];
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    stripe_byte_ram dut (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wr_en (wr_en),
        .wdata (wdata),
        .rdata (rdata)
    );

    function automatic logic [7:0] fill_val(input int a);
        return 8'((a * 37) ^ (a >> 5) ^ 8'h5A);
    endfunction

    task automatic note(input string tag, input logic [12:0] a,
                        input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, got, exp);
        end
    endtask

    // One access: drive at falling edge, check the registered result after the rising edge.
    task automatic step(input logic [12:0] a, input logic we, input logic [7:0] d,
                        input string tag, input bit chk);
        logic [7:0] exp;
        @(negedge clk);
        addr = a; wr_en = we; wdata = d;
        exp = model[a];
        if (we) model[a] = d;
        @(posedge clk);
        #1;
        if (chk) note(tag, a, rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1C0DE5));
        rst_n = 1'b0; addr = '0; wr_en = 1'b0; wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        note("R1 reset read", addr, rdata, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // Fill every byte, then read everything back.
        for (int a = 0; a < 8192; a++) step(13'(a), 1'b1, fill_val(a), "fill", 1'b0);
        for (int a = 0; a < 8192; a++)
            step(13'(a), 1'b0, 8'h00, (a >= 13'h1C00) ? "R3 striped readback" : "R2 bank readback", 1'b1);

        // Region boundary corners.
        step(13'h1BFF, 1'b1, 8'hC3, "R2 last bank byte write", 1'b1);
        step(13'h1C00, 1'b1, 8'h81, "R3 first striped write", 1'b1);
        step(13'h1FFF, 1'b1, 8'h7E, "R3 last striped write", 1'b1);
        step(13'h1BFF, 1'b0, 8'h00, "R2 read 0x1BFF", 1'b1);
        step(13'h1C00, 1'b0, 8'h00, "R3 read 0x1C00", 1'b1);
        step(13'h1FFF, 1'b0, 8'h00, "R3 read 0x1FFF", 1'b1);
        step(13'h03FF, 1'b0, 8'h00, "R5 bank0 idx 3FF after striped write", 1'b1);

        // Same index shared by all regions: single-bit striped values.
        for (int bit_i = 0; bit_i < 8; bit_i++) begin
            step(13'h1C55, 1'b1, 8'(1 << bit_i), "R3 striped walking one", 1'b0);
            step(13'h1C55, 1'b0, 8'h00, "R3 striped walking one", 1'b1);
            for (int b = 0; b < 7; b++)
                step(13'((b << 10) | 10'h055), 1'b0, 8'h00, "R5 low bytes after striped write", 1'b1);
        end
        for (int b = 0; b < 7; b++) begin
            step(13'((b << 10) | 10'h055), 1'b1, 8'hFF ^ 8'(b), "R4 bank write shared idx", 1'b0);
            step(13'h1C55, 1'b0, 8'h00, "R4 striped byte kept", 1'b1);
        end
        for (int b = 0; b < 7; b++)
            step(13'((b << 10) | 10'h055), 1'b0, 8'h00, "R4 other banks kept", 1'b1);

        // Collision and idle cases.
        step(13'h0A10, 1'b1, 8'h3C, "R7 read during write old", 1'b1);
        step(13'h0A10, 1'b0, 8'h00, "R6 next-cycle read", 1'b1);
        step(13'h1E10, 1'b1, 8'hA5, "R7 striped read during write", 1'b1);
        step(13'h1E10, 1'b0, 8'h96, "R8 idle leaves data", 1'b1);
        step(13'h1E10, 1'b0, 8'h00, "R8 idle leaves data", 1'b1);

        // Random traffic clustered on a few word indices.
        for (int n = 0; n < 6000; n++) begin
            logic [12:0] a;
            logic we;
            a  = {3'($urandom_range(0, 7)), 10'($urandom_range(0, 3) * 10'h111)};
            if ($urandom_range(0, 3) == 0) a = 13'($urandom_range(0, 8191));
            we = ($urandom_range(0, 1) == 1);
            step(a, we, 8'($urandom), we ? "R7 random write cycle" : "R6 random read", 1'b1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule